// File: doc/BRIEF.md
# ISA Byte-Pair to IDE Word Bridge

This block lets an 8-bit ISA host move 16-bit IDE data words as two back-to-back byte cycles. The drive registers are decoded at a fixed base address with no swapping of address lines. The word data register is the even port at offset 0, and its upper-byte companion is the odd port at offset 1.

On a read, the access to the even port runs a real drive read. The block returns the low byte to the host and keeps the high byte in a holding register. An immediately following read of the odd port is then answered from that register, with no drive cycle. On a write, the even-port byte is held back. The next write to the odd port issues one 16-bit drive write that carries both bytes. Any other access in between cancels the pairing, and that access proceeds as an ordinary byte transfer.

The host strobes are synchronised into the block clock, and the block acts on their edges. This relies on the host issuing each word as low byte then high byte without interruption. Cycles with the address-enable line high are DMA cycles, and the block ignores them.

Top module: `isa_ide_pair_bridge`

## Requirements
- R1: Ports BASE_ADDR to BASE_ADDR+7 are decoded (default 0x300). `ide_reg` carries the low three address bits. `ide_cs_n` is low whenever a drive strobe is low. `ide_rd_n` and `ide_wr_n` are never low together.
- R2: A read of offset 0 pulses `ide_rd_n`. It returns `ide_din[7:0]` on `isa_dout`, keeps `ide_din[15:8]`, and arms read pairing.
- R3: A read of offset 1 while read pairing is armed returns the kept high byte with no `ide_rd_n` pulse, then disarms.
- R4: Read pairing is disarmed by a read of any other port, by a read of an undecoded port, or by any write. Each of these proceeds normally.
- R5: A write to offset 0 produces no `ide_wr_n` pulse. It keeps the written byte and arms write pairing.
- R6: A write to offset 1 while write pairing is armed pulses `ide_wr_n` once, with `ide_dout` = {current byte, kept byte}.
- R7: Any access other than an offset-1 write disarms write pairing, and that access proceeds normally.
- R8: An unpaired access to offset 1 is forwarded to drive register 1. An unpaired write drives `ide_dout` = {8'h00, byte}.
- R9: Cycles with `isa_aen` high cause no drive strobe and leave both pairing states unchanged.
- R10: `isa_doe` is high only within a host read of a decoded port. `ide_doe` is high only while `ide_wr_n` is low.
- R11: Synchronous reset disarms both pairings, clears both kept bytes, deasserts every strobe, and drops both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_addr | input | ADDR_W | Host I/O address |
| isa_din | input | 8 | Host write data |
| isa_dout | output | 8 | Host read data |
| isa_doe | output | 1 | Host data bus drive enable |
| isa_ior_n | input | 1 | Host I/O read strobe, active low |
| isa_iow_n | input | 1 | Host I/O write strobe, active low |
| isa_aen | input | 1 | Address enable, high during DMA |
| ide_cs_n | output | 1 | Drive command-block select, active low |
| ide_reg | output | REG_W | Drive register offset |
| ide_rd_n | output | 1 | Drive read strobe, active low |
| ide_wr_n | output | 1 | Drive write strobe, active low |
| ide_din | input | 16 | Drive read data |
| ide_dout | output | 16 | Drive write data |
| ide_doe | output | 1 | Drive data bus drive enable |

## Verification
The checker watches, on every cycle, the properties that hold at the strobes themselves. Select accompanies every strobe, and the two strobes are never low together. Each drive strobe traces back to a host strobe with AEN low. An even-port write never produces a write strobe. The two drive enables stay tied to the correct cycle type, and the outputs are quiet after reset.

Whether a read is answered from the kept byte rather than from the drive depends on the history of earlier accesses. So do the word contents of a paired write and the cancelling of pairing by an intervening access, DMA cycle or reset. Only the bench's access sequences can show these.

// File: rtl/isa_ide_pair_pkg.sv
package isa_ide_pair_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_IDE,
    ST_RD_HOLD,
    ST_WR_LATCH,
    ST_WR_IDE
  } pair_state_e;

  localparam int unsigned LO_OFS = 0;
  localparam int unsigned HI_OFS = 1;
endpackage

// File: rtl/isa_sampler.sv
module isa_sampler #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/isa_port_decoder.sv
module isa_port_decoder #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned REG_W  = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [REG_W-1:0]  offset
);
  localparam int unsigned TOP_W = ADDR_W - REG_W;
  localparam logic [TOP_W-1:0] BASE_TOP = BASE_ADDR[ADDR_W-1:REG_W];

  always_comb begin
    hit    = (addr[ADDR_W-1:REG_W] == BASE_TOP);
    offset = addr[REG_W-1:0];
  end
endmodule

// File: rtl/isa_pair_ctrl.sv
module isa_pair_ctrl
  import isa_ide_pair_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned REG_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ior_n,
  input  logic                iow_n,
  input  logic                aen,
  input  logic                hit,
  input  logic [REG_W-1:0]    offset,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [2*BYTE_W-1:0] ide_din,
  output logic [BYTE_W-1:0]   isa_dout,
  output logic                isa_doe,
  output logic                ide_cs_n,
  output logic [REG_W-1:0]    ide_reg,
  output logic                ide_rd_n,
  output logic                ide_wr_n,
  output logic [2*BYTE_W-1:0] ide_dout,
  output logic                ide_doe
);
  localparam logic [REG_W-1:0] OFS_LO = REG_W'(LO_OFS);
  localparam logic [REG_W-1:0] OFS_HI = REG_W'(HI_OFS);

  pair_state_e       state;
  logic              prev_ior_n, prev_iow_n;
  logic              rd_pend, wr_pend;
  logic              even_q, paired_q;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              ior_fall, ior_rise, iow_fall, iow_rise;
  logic              is_lo, is_hi;

  always_comb begin
    ior_fall = prev_ior_n & ~ior_n;
    ior_rise = ~prev_ior_n & ior_n;
    iow_fall = prev_iow_n & ~iow_n;
    iow_rise = ~prev_iow_n & iow_n;
    is_lo    = (offset == OFS_LO);
    is_hi    = (offset == OFS_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prev_ior_n <= 1'b1;
      prev_iow_n <= 1'b1;
      rd_pend    <= 1'b0;
      wr_pend    <= 1'b0;
      even_q     <= 1'b0;
      paired_q   <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
      isa_dout   <= '0;
      isa_doe    <= 1'b0;
      ide_cs_n   <= 1'b1;
      ide_reg    <= '0;
      ide_rd_n   <= 1'b1;
      ide_wr_n   <= 1'b1;
      ide_dout   <= '0;
      ide_doe    <= 1'b0;
    end else begin
      prev_ior_n <= ior_n;
      prev_iow_n <= iow_n;
      case (state)
        ST_IDLE: begin
          if (ior_fall && !aen) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            if (hit) begin
              isa_doe <= 1'b1;
              if (is_hi && rd_pend) begin
                state    <= ST_RD_HOLD;
                isa_dout <= hi_q;
              end else begin
                state    <= ST_RD_IDE;
                even_q   <= is_lo;
                ide_reg  <= offset;
                ide_cs_n <= 1'b0;
                ide_rd_n <= 1'b0;
                isa_dout <= ide_din[BYTE_W-1:0];
              end
            end
          end else if (iow_fall && !aen) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            if (hit) begin
              if (is_lo) begin
                state <= ST_WR_LATCH;
                lo_q  <= wdata;
              end else begin
                state    <= ST_WR_IDE;
                paired_q <= is_hi && wr_pend;
                ide_reg  <= offset;
                ide_cs_n <= 1'b0;
                ide_wr_n <= 1'b0;
                ide_doe  <= 1'b1;
                ide_dout <= (is_hi && wr_pend) ? {wdata, lo_q}
                                               : {{BYTE_W{1'b0}}, wdata};
              end
            end
          end
        end
        ST_RD_IDE: begin
          isa_dout <= ide_din[BYTE_W-1:0];
          if (ior_rise) begin
            if (even_q) hi_q <= ide_din[2*BYTE_W-1:BYTE_W];
            rd_pend  <= even_q;
            ide_rd_n <= 1'b1;
            ide_cs_n <= 1'b1;
            isa_doe  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_RD_HOLD: begin
          if (ior_rise) begin
            isa_doe <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_WR_LATCH: begin
          lo_q <= wdata;
          if (iow_rise) begin
            wr_pend <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_WR_IDE: begin
          ide_dout <= paired_q ? {wdata, lo_q} : {{BYTE_W{1'b0}}, wdata};
          if (iow_rise) begin
            ide_wr_n <= 1'b1;
            ide_cs_n <= 1'b1;
            ide_doe  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_ide_pair_bridge.sv
module isa_ide_pair_bridge #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned REG_W  = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   isa_addr,
  input  logic [BYTE_W-1:0]   isa_din,
  output logic [BYTE_W-1:0]   isa_dout,
  output logic                isa_doe,
  input  logic                isa_ior_n,
  input  logic                isa_iow_n,
  input  logic                isa_aen,
  output logic                ide_cs_n,
  output logic [REG_W-1:0]    ide_reg,
  output logic                ide_rd_n,
  output logic                ide_wr_n,
  input  logic [2*BYTE_W-1:0] ide_din,
  output logic [2*BYTE_W-1:0] ide_dout,
  output logic                ide_doe
);
  localparam int unsigned SAMP_W = 3 + ADDR_W + BYTE_W;
  localparam logic [SAMP_W-1:0] SAMP_RST = {3'b111, {(ADDR_W+BYTE_W){1'b0}}};

  logic [SAMP_W-1:0] samp_d, samp_q;
  logic              s_aen, s_ior_n, s_iow_n;
  logic [ADDR_W-1:0] s_addr;
  logic [BYTE_W-1:0] s_data;
  logic              dec_hit;
  logic [REG_W-1:0]  dec_ofs;

  assign samp_d = {isa_aen, isa_ior_n, isa_iow_n, isa_addr, isa_din};
  assign {s_aen, s_ior_n, s_iow_n, s_addr, s_data} = samp_q;

  isa_sampler #(
    .W(SAMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SAMP_RST)
  ) u_sampler (
    .clk(clk), .rst(rst), .d(samp_d), .q(samp_q)
  );

  isa_port_decoder #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .BASE_ADDR(BASE_ADDR)
  ) u_decoder (
    .addr(s_addr), .hit(dec_hit), .offset(dec_ofs)
  );

  isa_pair_ctrl #(
    .BYTE_W(BYTE_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .ior_n(s_ior_n), .iow_n(s_iow_n), .aen(s_aen),
    .hit(dec_hit), .offset(dec_ofs), .wdata(s_data),
    .ide_din(ide_din),
    .isa_dout(isa_dout), .isa_doe(isa_doe),
    .ide_cs_n(ide_cs_n), .ide_reg(ide_reg),
    .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_dout(ide_dout), .ide_doe(ide_doe)
  );
endmodule

// File: rtl/isa_ide_pair_checker.sv
module isa_ide_pair_checker #(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] isa_addr,
  input logic              isa_ior_n,
  input logic              isa_iow_n,
  input logic              isa_aen,
  input logic              isa_doe,
  input logic              ide_cs_n,
  input logic              ide_rd_n,
  input logic              ide_wr_n,
  input logic              ide_doe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ide_rd_n && !ide_wr_n)); // R1
  AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!ide_rd_n || !ide_wr_n) |-> !ide_cs_n); // R1
  AST_EVEN_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(ide_wr_n) |-> ($past(isa_addr, 2) != BASE_ADDR)); // R5
  AST_RD_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
    $fell(ide_rd_n) |-> (!$past(isa_ior_n, 2) && !$past(isa_aen, 2))); // R9
  AST_WR_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
    $fell(ide_wr_n) |-> (!$past(isa_iow_n, 2) && !$past(isa_aen, 2))); // R9
  AST_ISA_DOE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(isa_doe) |-> (!$past(isa_ior_n, 2) && !$past(isa_aen, 2))); // R10
  AST_IDE_DOE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    ide_doe |-> !ide_wr_n); // R10
  AST_NO_ISA_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ide_wr_n |-> !isa_doe); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ide_rd_n && ide_wr_n && ide_cs_n && !isa_doe && !ide_doe)); // R11
endmodule

bind isa_ide_pair_bridge isa_ide_pair_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_checker (.*);

// File: tb/test_isa_ide_pair_bridge.sv
`timescale 1ns/1ps
module test_isa_ide_pair_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  isa_addr = '0;
  logic [7:0]  isa_din = '0;
  logic [7:0]  isa_dout;
  logic        isa_doe;
  logic        isa_ior_n = 1'b1;
  logic        isa_iow_n = 1'b1;
  logic        isa_aen = 1'b0;
  logic        ide_cs_n;
  logic [2:0]  ide_reg;
  logic        ide_rd_n, ide_wr_n;
  logic [15:0] ide_din = '0;
  logic [15:0] ide_dout;
  logic        ide_doe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  isa_ide_pair_bridge i_isa_ide_pair_bridge (.*);

  // {tag[57:54], wr[53], aen[52], addr[51:42], data[41:34], ide_word[33:18],
  //  exp_strobe[17], exp_value[16:1] (read: low byte on isa_dout, write: ide_dout), exp_enable[0]}
  localparam int NV = 20;
  localparam logic [57:0] VEC [NV] = '{
    {4'd2,  1'b0,1'b0,10'h300,8'h00,16'hBEEF,1'b1,16'h00EF,1'b1}, // R2 even read
    {4'd3,  1'b0,1'b0,10'h301,8'h00,16'h1234,1'b0,16'h00BE,1'b1}, // R3 paired odd read
    {4'd8,  1'b0,1'b0,10'h301,8'h00,16'h5678,1'b1,16'h0078,1'b1}, // R8 unpaired odd read
    {4'd2,  1'b0,1'b0,10'h300,8'h00,16'hCAFE,1'b1,16'h00FE,1'b1}, // R2
    {4'd10, 1'b0,1'b0,10'h310,8'h00,16'h0000,1'b0,16'h0000,1'b0}, // R10 undecoded read
    {4'd4,  1'b0,1'b0,10'h301,8'h00,16'h0042,1'b1,16'h0042,1'b1}, // R4 cleared by other port
    {4'd5,  1'b1,1'b0,10'h300,8'h11,16'h0000,1'b0,16'h0000,1'b0}, // R5 even write
    {4'd6,  1'b1,1'b0,10'h301,8'h22,16'h0000,1'b1,16'h2211,1'b1}, // R6 paired write
    {4'd5,  1'b1,1'b0,10'h300,8'h33,16'h0000,1'b0,16'h0000,1'b0}, // R5
    {4'd7,  1'b0,1'b0,10'h307,8'h00,16'h0050,1'b1,16'h0050,1'b1}, // R7 intervening read
    {4'd7,  1'b1,1'b0,10'h301,8'h44,16'h0000,1'b1,16'h0044,1'b1}, // R7 write now unpaired
    {4'd2,  1'b0,1'b0,10'h300,8'h00,16'h9A9B,1'b1,16'h009B,1'b1}, // R2
    {4'd1,  1'b1,1'b0,10'h305,8'h66,16'h0000,1'b1,16'h0066,1'b1}, // R1 reg offset 5
    {4'd4,  1'b0,1'b0,10'h301,8'h00,16'h0001,1'b1,16'h0001,1'b1}, // R4 cleared by write
    {4'd2,  1'b0,1'b0,10'h300,8'h00,16'hABCD,1'b1,16'h00CD,1'b1}, // R2
    {4'd9,  1'b0,1'b1,10'h302,8'h00,16'h0000,1'b0,16'h0000,1'b0}, // R9 DMA read
    {4'd9,  1'b0,1'b0,10'h301,8'h00,16'h7777,1'b0,16'h00AB,1'b1}, // R9 pairing survives
    {4'd5,  1'b1,1'b0,10'h300,8'h77,16'h0000,1'b0,16'h0000,1'b0}, // R5
    {4'd9,  1'b1,1'b1,10'h304,8'h00,16'h0000,1'b0,16'h0000,1'b0}, // R9 DMA write
    {4'd6,  1'b1,1'b0,10'h301,8'h88,16'h0000,1'b1,16'h8877,1'b1}  // R6 after DMA
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input int tag, input logic wr, input logic aen,
                        input logic [9:0] addr, input logic [7:0] d,
                        input logic [15:0] idew, input logic exp_strobe,
                        input logic [15:0] exp_val, input logic exp_en);
    string req;
    logic  strobe;
    req = $sformatf("R%0d", tag);
    @(negedge clk);
    isa_addr = addr; isa_din = d; isa_aen = aen; ide_din = idew;
    @(negedge clk);
    if (wr) isa_iow_n = 1'b0; else isa_ior_n = 1'b0;
    repeat (5) @(negedge clk);
    strobe = wr ? !ide_wr_n : !ide_rd_n;
    check(req, "drive strobe", 16'(strobe), 16'(exp_strobe));
    if (exp_strobe) begin
      check(req, "select", 16'(ide_cs_n), 16'h0);
      check(req, "register", 16'(ide_reg), 16'(addr[2:0]));
    end
    if (wr) begin
      check(req, "ide_doe", 16'(ide_doe), 16'(exp_en));
      check(req, "isa_doe in write", 16'(isa_doe), 16'h0);
      if (exp_strobe) check(req, "ide_dout", ide_dout, exp_val);
    end else begin
      check(req, "isa_doe", 16'(isa_doe), 16'(exp_en));
      if (exp_en) check(req, "isa_dout", 16'(isa_dout), exp_val);
    end
    isa_ior_n = 1'b1; isa_iow_n = 1'b1;
    repeat (6) @(negedge clk);
    isa_aen = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R11 idle outputs after reset
    check("R11", "rd_n", 16'(ide_rd_n), 16'h1);
    check("R11", "wr_n", 16'(ide_wr_n), 16'h1);
    check("R11", "cs_n", 16'(ide_cs_n), 16'h1);
    check("R11", "enables", {14'h0, isa_doe, ide_doe}, 16'h0);
    for (int i = 0; i < NV; i++) begin
      access(int'(VEC[i][57:54]), VEC[i][53], VEC[i][52], VEC[i][51:42],
             VEC[i][41:34], VEC[i][33:18], VEC[i][17], VEC[i][16:1], VEC[i][0]);
    end
    // R11 reset cancels read pairing: odd read goes to the drive
    access(2, 1'b0, 1'b0, 10'h300, 8'h00, 16'hF00D, 1'b1, 16'h000D, 1'b1);
    pulse_reset();
    access(11, 1'b0, 1'b0, 10'h301, 8'h00, 16'h0009, 1'b1, 16'h0009, 1'b1);
    // R11 reset cancels write pairing and clears the kept byte
    access(5, 1'b1, 1'b0, 10'h300, 8'h5A, 16'h0000, 1'b0, 16'h0000, 1'b0);
    pulse_reset();
    access(11, 1'b1, 1'b0, 10'h301, 8'hA5, 16'h0000, 1'b1, 16'h00A5, 1'b1);
    // R8 unpaired odd write after an unrelated port access
    access(4, 1'b0, 1'b0, 10'h280, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0);
    access(8, 1'b1, 1'b0, 10'h301, 8'hC3, 16'h0000, 1'b1, 16'h00C3, 1'b1);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule